// File: doc/BRIEF.md
# Serial Bus Byte Talker

This block is the sending side of a three-wire, open-collector peripheral bus that has an attention line, a clock line and a data line. The host hands it one byte together with two flags. The first flag marks the byte as the last of a stream (end-of-data). The second flag marks the byte as a command byte that is sent while attention is held. The block then runs the complete handshake with the listeners on the bus. It drives the attention and clock lines through pull-down enables. It also uses the data line both for the bits it sends and for the handshakes it receives. When the byte is finished it pulses done, and it raises error on the same cycle if the handshake failed.

All time intervals are counted in pulses of a one-microsecond tick input, so the block works at any system clock rate. Before every byte it waits a fixed gap. It then releases the clock line and waits until every listener has released data. If end-of-data was requested, it keeps the clock line released until a listener has answered with a low pulse on data. It then sends eight bits, least significant first, and waits for the listener to pull data low as the acknowledge. For a command byte, attention is asserted first. After a settle time the block checks that some device is holding data low. If none is, the block stops with an error. Address codes such as device OR 0x20 (listen), device OR 0x40 (talk) and 0x3F (unlisten) are formed by the host and sent as ordinary command bytes.

Top module: `sbus_talker`

## Requirements
- R1: Idle state. After reset, and whenever no byte is in progress, the enables are as follows: clock asserted (`clk_oe`=1), attention released (`atn_oe`=0) and data released (`data_oe`=0). `busy` and `done` are low in this state.
- R2: Gap. After a byte is accepted, at least GAP_US ticks pass before the clock line is released. For a command byte this gap follows the attention settle time.
- R3: Listener ready. After releasing the clock, the block sends no bit until the bus data line reads high (1 = released). It holds the clock released for as long as any listener keeps data low.
- R4: Bit order and polarity. Bits go out least significant first. A 1 bit is sent as data released (`data_oe`=0) and a 0 bit as data asserted (`data_oe`=1). The data level does not change while the clock is released within a bit.
- R5: Bit timing. Each bit holds the clock asserted for 2×BIT_US ticks: BIT_US ticks with data released, then BIT_US ticks with the bit value driven. It then holds the clock released for BIT_US ticks.
- R6: End-of-data. When `tx_eoi`=1, the block keeps the clock released after the listeners are ready. It waits until data goes low and then high again before the first bit. When `tx_eoi`=0 it starts the bits with no such wait.
- R7: End-of-data timeout. If the low pulse, or its return to high, does not arrive within EOI_TIMEOUT_US ticks, the block ends with `done` and `error` both high.
- R8: Command byte. When `tx_atn`=1, attention is asserted together with the clock for ATN_SETTLE_US ticks. Attention stays asserted while the byte is sent, and it is released when `done` pulses.
- R9: No device. If the data line reads high at the end of the attention settle time, the block ends with `error`. It releases attention and never releases the clock, so no bit is sent.
- R10: Acknowledge. After the eighth bit the clock is asserted again. The byte completes without error when data reads low within ACK_TIMEOUT_US ticks; otherwise the block ends with `error`.
- R11: Completion. `done` is a single-cycle pulse. `busy` is high from the cycle after a start is accepted until `done` and is low with `done`. `start` is only accepted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin sending a byte; only accepted while idle |
| tx_byte | input | DATA_W | Byte to send |
| tx_eoi | input | 1 | Mark this byte as end-of-data |
| tx_atn | input | 1 | Send this byte as a command under attention |
| data_in | input | 1 | Bus data level, 1 = released |
| atn_oe | output | 1 | Pull the attention line low |
| clk_oe | output | 1 | Pull the clock line low |
| data_oe | output | 1 | Pull the data line low |
| busy | output | 1 | Byte in progress |
| done | output | 1 | One-cycle pulse at the end of a byte |
| error | output | 1 | With done: the handshake failed |

## Verification
Every one of the 256 byte values is sent with end-of-data clear, and a model listener receives it from the bus lines. A swapped bit order, an inverted polarity or a lost bit then shows up as a wrong received byte. The same transfers measure the clock low and high widths, and the time from start to the first clock release. Further runs use a listener that holds off readiness, bytes with end-of-data marked (where the listener must answer the long clock-release), and command codes under attention. These separate the two hold-off waits from the ordinary path. A listener that never answers end-of-data, one that never acknowledges, and an empty bus under attention each exercise a different error exit, and each exit is checked for its effect on attention and on the bits sent.

// File: rtl/sbus_talker_pkg.sv
package sbus_talker_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ATN,
    ST_GAP,
    ST_READY,
    ST_EOI_LO,
    ST_EOI_HI,
    ST_BIT_SETUP,
    ST_BIT_DRIVE,
    ST_BIT_HOLD,
    ST_ACK
  } talk_state_e;
endpackage

// File: rtl/sbus_us_timer.sv
module sbus_us_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sbus_bit_shifter.sv
module sbus_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         lsb,
  output logic         last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sr;
  logic [CW-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      sent <= '0;
    end else if (load) begin
      sr   <= din;
      sent <= '0;
    end else if (shift) begin
      sr   <= sr >> 1;
      sent <= sent + 1'b1;
    end
  end

  assign lsb  = sr[0];
  assign last = (sent == CW'(W - 1));
endmodule

// File: rtl/sbus_talker.sv
module sbus_talker
  import sbus_talker_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int GAP_US         = 100,
  parameter int ATN_SETTLE_US  = 1000,
  parameter int BIT_US         = 20,
  parameter int EOI_TIMEOUT_US = 1000,
  parameter int ACK_TIMEOUT_US = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_eoi,
  input  logic              tx_atn,
  input  logic              data_in,
  output logic              atn_oe,
  output logic              clk_oe,
  output logic              data_oe,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int MAX_A = (GAP_US > ATN_SETTLE_US) ? GAP_US : ATN_SETTLE_US;
  localparam int MAX_B = (BIT_US > EOI_TIMEOUT_US) ? BIT_US : EOI_TIMEOUT_US;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMAX  = (MAX_C > ACK_TIMEOUT_US) ? MAX_C : ACK_TIMEOUT_US;
  localparam int TW    = $clog2(TMAX + 1);

  localparam logic [TW-1:0] T_GAP = TW'(GAP_US - 1);
  localparam logic [TW-1:0] T_ATN = TW'(ATN_SETTLE_US - 1);
  localparam logic [TW-1:0] T_BIT = TW'(BIT_US - 1);
  localparam logic [TW-1:0] T_EOI = TW'(EOI_TIMEOUT_US - 1);
  localparam logic [TW-1:0] T_ACK = TW'(ACK_TIMEOUT_US - 1);

  talk_state_e   state_q, state_d;
  logic          cmd_q, cmd_d, eoi_q;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          sh_load, sh_shift, sh_lsb, sh_last;
  logic          fin, fail;

  sbus_us_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .tick(tick_us), .expired(t_exp)
  );

  sbus_bit_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .din(tx_byte),
    .shift(sh_shift), .lsb(sh_lsb), .last(sh_last)
  );

  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    fin      = 1'b0;
    fail     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        sh_load = 1'b1;
        t_load  = 1'b1;
        if (tx_atn) begin
          state_d = ST_ATN;
          t_val   = T_ATN;
        end else begin
          state_d = ST_GAP;
          t_val   = T_GAP;
        end
      end
      ST_ATN: if (t_exp) begin
        if (data_in) begin
          fin     = 1'b1;
          fail    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_GAP;
          t_load  = 1'b1;
          t_val   = T_GAP;
        end
      end
      ST_GAP: if (t_exp) state_d = ST_READY;
      ST_READY: if (data_in) begin
        t_load = 1'b1;
        if (eoi_q) begin
          state_d = ST_EOI_LO;
          t_val   = T_EOI;
        end else begin
          state_d = ST_BIT_SETUP;
          t_val   = T_BIT;
        end
      end
      ST_EOI_LO: begin
        if (!data_in) begin
          state_d = ST_EOI_HI;
          t_load  = 1'b1;
          t_val   = T_EOI;
        end else if (t_exp) begin
          fin     = 1'b1;
          fail    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_EOI_HI: begin
        if (data_in) begin
          state_d = ST_BIT_SETUP;
          t_load  = 1'b1;
          t_val   = T_BIT;
        end else if (t_exp) begin
          fin     = 1'b1;
          fail    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_BIT_SETUP: if (t_exp) begin
        state_d = ST_BIT_DRIVE;
        t_load  = 1'b1;
        t_val   = T_BIT;
      end
      ST_BIT_DRIVE: if (t_exp) begin
        state_d = ST_BIT_HOLD;
        t_load  = 1'b1;
        t_val   = T_BIT;
      end
      ST_BIT_HOLD: if (t_exp) begin
        sh_shift = 1'b1;
        t_load   = 1'b1;
        if (sh_last) begin
          state_d = ST_ACK;
          t_val   = T_ACK;
        end else begin
          state_d = ST_BIT_SETUP;
          t_val   = T_BIT;
        end
      end
      ST_ACK: begin
        if (!data_in) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else if (t_exp) begin
          fin     = 1'b1;
          fail    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cmd_d = sh_load ? tx_atn : cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= 1'b0;
      eoi_q   <= 1'b0;
      atn_oe  <= 1'b0;
      clk_oe  <= 1'b1;
      data_oe <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      if (sh_load) eoi_q <= tx_eoi;
      atn_oe  <= (state_d != ST_IDLE) && cmd_d;
      clk_oe  <= !(state_d inside {ST_READY, ST_EOI_LO, ST_EOI_HI, ST_BIT_HOLD});
      data_oe <= (state_d inside {ST_BIT_DRIVE, ST_BIT_HOLD}) && !sh_lsb;
      busy    <= (state_d != ST_IDLE);
      done    <= fin;
      error   <= fail;
    end
  end
endmodule

// File: rtl/sbus_talker_chk.sv
module sbus_talker_chk (
  input logic clk,
  input logic rst,
  input logic atn_oe,
  input logic clk_oe,
  input logic data_oe,
  input logic busy,
  input logic done,
  input logic error
);
  // R1: reset leaves the bus in its idle drive pattern
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (clk_oe && !atn_oe && !data_oe && !busy && !done));

  // R4: data level frozen while the clock line is released
  a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
    (!clk_oe && $past(!clk_oe)) |-> $stable(data_oe));

  // R8: attention is only ever driven during a byte
  a_r8_atn_in_byte: assert property (@(posedge clk) disable iff (rst)
    atn_oe |-> busy);

  // R10: error is only reported together with completion
  a_r10_error_with_done: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  // R11: completion pulse is single-cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: busy is low with done
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: busy only ends through done
  a_r11_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind sbus_talker sbus_talker_chk u_chk (
  .clk(clk), .rst(rst), .atn_oe(atn_oe), .clk_oe(clk_oe),
  .data_oe(data_oe), .busy(busy), .done(done), .error(error)
);

// File: tb/sbus_talker_bench.sv
module sbus_talker_bench;
  localparam int GAP_T = 4;
  localparam int ATN_T = 10;
  localparam int BIT_T = 2;
  localparam int EOI_T = 20;
  localparam int ACK_T = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_eoi = 1'b0;
  logic tx_atn = 1'b0;
  logic atn_oe, clk_oe, data_oe, busy, done, error;
  logic l_pull = 1'b0;
  logic bus_data, bus_clk;

  assign bus_data = ~(data_oe | l_pull);
  assign bus_clk  = ~clk_oe;

  always #2.5 clk = ~clk;

  sbus_talker #(
    .DATA_W(8), .GAP_US(GAP_T), .ATN_SETTLE_US(ATN_T), .BIT_US(BIT_T),
    .EOI_TIMEOUT_US(EOI_T), .ACK_TIMEOUT_US(ACK_T)
  ) u_sbus_talker (
    .clk(clk), .rst(rst), .tick_us(1'b1), .start(start), .tx_byte(tx_byte),
    .tx_eoi(tx_eoi), .tx_atn(tx_atn), .data_in(bus_data), .atn_oe(atn_oe),
    .clk_oe(clk_oe), .data_oe(data_oe), .busy(busy), .done(done), .error(error)
  );

  int errors = 0;
  int total = 0;
  bit finished = 1'b0;

  // listener model controls and observations
  bit l_present = 1'b1;
  bit l_eoi_en = 1'b1;
  bit l_ack_en = 1'b1;
  int l_ready_dly = 0;
  int l_ack_dly = 2;
  logic [7:0] rx_byte = 8'h00;
  bit rx_eoi = 1'b0;
  int rx_count = 0;
  int lo_min, lo_max, hi_min, hi_max;
  int ln, lo, hi;
  logic [7:0] lr;
  bit lok, leoi;

  // send results
  bit r_err, r_atn_rel, r_busy1, r_got;
  int r_rel, r_rel_len, cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : listener
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      l_pull = l_present;
      @(negedge clk);
      while (!bus_clk) @(negedge clk);
      ln = 0;
      while (ln < l_ready_dly) begin @(negedge clk); ln++; end
      l_pull = 1'b0;
      lok = 1'b1; leoi = 1'b0; ln = 0;
      @(negedge clk);
      while (bus_clk && busy) begin
        ln++;
        if (ln == 5 && l_eoi_en && l_present) begin
          l_pull = 1'b1;
          repeat (4) @(negedge clk);
          l_pull = 1'b0;
          leoi = 1'b1;
        end
        @(negedge clk);
      end
      if (!busy) lok = 1'b0;
      if (lok) begin
        lr = 8'h00; lo_min = 99; lo_max = 0; hi_min = 99; hi_max = 0;
        for (int i = 0; i < 8; i++) begin
          if (lok) begin
            lo = 1;
            @(negedge clk);
            while (!bus_clk && busy) begin lo++; @(negedge clk); end
            if (!busy) lok = 1'b0;
            else begin
              lr[i] = bus_data;
              hi = 1;
              @(negedge clk);
              while (bus_clk && busy) begin hi++; @(negedge clk); end
              if (lo < lo_min) lo_min = lo;
              if (lo > lo_max) lo_max = lo;
              if (i < 7) begin
                if (hi < hi_min) hi_min = hi;
                if (hi > hi_max) hi_max = hi;
              end
            end
          end
        end
        if (lok) begin
          ln = 0;
          while (ln < l_ack_dly) begin @(negedge clk); ln++; end
          rx_byte = lr; rx_eoi = leoi; rx_count++;
          if (l_ack_en && l_present) l_pull = 1'b1;
          else while (busy) @(negedge clk);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic eoi, input logic atn);
    @(negedge clk);
    start = 1'b1; tx_byte = b; tx_eoi = eoi; tx_atn = atn;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; r_rel = 0; r_rel_len = 0; r_got = 1'b0; r_err = 1'b0;
    r_atn_rel = 1'b0; r_busy1 = busy;
    while (!r_got && cyc < 3000) begin
      if (!clk_oe && r_rel == 0) begin r_rel = cyc; r_atn_rel = atn_oe; end
      if (clk_oe && r_rel != 0 && r_rel_len == 0) r_rel_len = cyc - r_rel;
      if (done) begin
        r_got = 1'b1; r_err = error;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    chk(r_got && r_busy1, "R11 done reached, busy from start", int'({r_got, r_busy1}), 3);
    @(negedge clk);
    chk(!done && !busy, "R11 done single pulse", int'({done, busy}), 0);
  endtask

  initial begin : main
    int cnt0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle drive pattern
    chk(clk_oe && !atn_oe && !data_oe && !busy && !done, "R1 reset idle",
        int'({clk_oe, atn_oe, data_oe, busy, done}), 5'b10000);

    // R4 / R5 / R2 / R6: exhaustive byte sweep, no end-of-data
    for (int v = 0; v < 256; v++) begin
      cnt0 = rx_count;
      send(8'(v), 1'b0, 1'b0);
      chk(!r_err && rx_count == cnt0 + 1 && rx_byte == 8'(v), "R4 byte LSB first",
          int'(rx_byte), v);
      chk(lo_min == 2*BIT_T && lo_max == 2*BIT_T && hi_min == BIT_T && hi_max == BIT_T,
          "R5 bit timing", lo_max*16 + hi_max, 2*BIT_T*16 + BIT_T);
      chk(r_rel > GAP_T, "R2 gap before clock release", r_rel, GAP_T + 1);
      chk(!rx_eoi, "R6 no end-of-data wait", int'(rx_eoi), 0);
    end
    chk(clk_oe && !data_oe && !atn_oe, "R1 idle after bytes",
        int'({clk_oe, data_oe, atn_oe}), 4);

    // R3 listener hold-off
    l_ready_dly = 15;
    send(8'h5A, 1'b0, 1'b0);
    chk(!r_err && rx_byte == 8'h5A, "R3 byte after hold-off", int'(rx_byte), 8'h5A);
    chk(r_rel_len >= 15, "R3 clock held released", r_rel_len, 15);
    l_ready_dly = 0;

    // R6 end-of-data handshake
    send(8'hA5, 1'b1, 1'b0);
    chk(!r_err && rx_byte == 8'hA5 && rx_eoi, "R6 eoi byte", int'({rx_eoi, rx_byte}), 9'h1A5);
    send(8'h00, 1'b1, 1'b0);
    chk(!r_err && rx_byte == 8'h00 && rx_eoi, "R6 eoi zero", int'({rx_eoi, rx_byte}), 9'h100);
    send(8'hFF, 1'b1, 1'b0);
    chk(!r_err && rx_byte == 8'hFF && rx_eoi, "R6 eoi ones", int'({rx_eoi, rx_byte}), 9'h1FF);

    // R8 command bytes: listen, talk, unlisten
    send(8'h28, 1'b0, 1'b1);
    chk(!r_err && rx_byte == 8'h28, "R8 listen code", int'(rx_byte), 8'h28);
    chk(r_atn_rel, "R8 attention held during bits", int'(r_atn_rel), 1);
    chk(r_rel > ATN_T + GAP_T, "R8 settle then gap", r_rel, ATN_T + GAP_T + 1);
    chk(!atn_oe, "R8 attention released after done", int'(atn_oe), 0);
    send(8'h48, 1'b0, 1'b1);
    chk(!r_err && rx_byte == 8'h48 && r_atn_rel, "R8 talk code", int'(rx_byte), 8'h48);
    send(8'h3F, 1'b0, 1'b1);
    chk(!r_err && rx_byte == 8'h3F && r_atn_rel, "R8 unlisten code", int'(rx_byte), 8'h3F);

    // R10 late acknowledge still inside timeout
    l_ack_dly = 9;
    send(8'hC3, 1'b0, 1'b0);
    chk(!r_err && rx_byte == 8'hC3, "R10 late ack accepted", int'(r_err), 0);
    l_ack_dly = 2;

    // R7 listener ignores end-of-data
    l_eoi_en = 1'b0;
    cnt0 = rx_count;
    send(8'h11, 1'b1, 1'b0);
    chk(r_err && rx_count == cnt0, "R7 eoi timeout error", int'(r_err), 1);
    l_eoi_en = 1'b1;

    // R10 present listener withholds acknowledge
    l_ack_en = 1'b0;
    send(8'h77, 1'b0, 1'b0);
    chk(r_err, "R10 no ack error", int'(r_err), 1);

    // R10 empty bus
    l_present = 1'b0;
    send(8'h66, 1'b0, 1'b0);
    chk(r_err, "R10 empty bus no ack", int'(r_err), 1);

    // R9 empty bus under attention
    cnt0 = rx_count;
    send(8'h28, 1'b0, 1'b1);
    chk(r_err, "R9 no device error", int'(r_err), 1);
    chk(r_rel == 0 && rx_count == cnt0, "R9 no clock release", r_rel, 0);
    chk(!atn_oe && clk_oe, "R9 attention released", int'({atn_oe, clk_oe}), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end
endmodule